// File: doc/BRIEF.md
# I2C Four-Way Channel Selector Control

This block is the digital control core of a bus selector that routes one upstream I2C bus to at most one of four downstream segments. It behaves as an I2C slave with a single byte-wide control register. A write to that register chooses which downstream segment, if any, is connected. The choice is presented as four one-hot enable outputs that steer the external pass switches.

Each downstream segment also has an active-low service-request line. The block synchronises the four lines and merges them into one active-low request output for the upstream host. This output is asserted whether or not the requesting segment is the one currently connected. When the host reads the control register, it receives the per-segment request state in the upper nibble and the stored selection in the low bits. The host can then find the requesting segment, select it and service the device.

The block runs on a system clock that is much faster than the bus clock. It oversamples SCL and SDA through synchronisers. Its SDA output is a pull-low enable for an external open-drain driver.

Top module: `i2c_chan_sel`

## Requirements
- R1: The slave answers the 7-bit address formed by the fixed upper nibble 4'b1110 followed by `addr_strap[2:0]`. It pulls SDA low in the acknowledge slot of that address byte, for both write (R/W bit 0) and read (R/W bit 1). It also pulls SDA low in the acknowledge slot of every data byte written to it.
- R2: When a transfer carries any other address, SDA is never pulled low and the stored selection does not change.
- R3: A written byte with bit 2 equal to 0 leaves every `chan_en` bit low once applied, whatever bits 1:0 hold.
- R4: A written byte with bit 2 equal to 1 makes `chan_en[bits 1:0]` the only high enable once applied. If several bytes are written in one transfer, the last one decides.
- R5: A written selection is applied only when the STOP condition is seen. `chan_en` changes three clock edges after SDA rises while SCL is high, and never at any other time.
- R6: After reset, `chan_en` is 4'b0000, `irq_n_out` is 1, `sda_oe` is 0, and a register read returns 8'h00.
- R7: `irq_n_out` is 0 while any `irq_n_in` bit is 0, independent of the current selection. It returns to 1 once all inputs are 1, with nothing held over.
- R8: In read data, bit 7 reports channel 3, bit 6 channel 2, bit 5 channel 1 and bit 4 channel 0. A bit is 1 when the corresponding `irq_n_in` is 0. All pending channels are reported together.
- R9: In read data, bit 3 is 0 and bits 2:0 are the applied selection. Bits 7:3 of a written byte have no effect.
- R10: Each `irq_n_in` bit passes through two flip-flops, so `irq_n_out` reflects an input change after exactly two rising clock edges.
- R11: The request state is captured when each read byte is loaded. For the first byte this happens at the end of the address acknowledge; for later bytes it happens after the host acknowledges the previous byte. A host NACK ends the read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | High to pull the data line low |
| addr_strap | input | 3 | Low three bits of the slave address |
| irq_n_in | input | 4 | Active-low service requests, one per downstream channel |
| chan_en | output | 4 | One-hot downstream channel enables |
| irq_n_out | output | 1 | Active-low merged service request |

## Verification
The bench targets several corner cases, each paired with the failure a wrong design would show:
- A write with the enable bit clear but a nonzero index: a decoder that ignores bit 2 turns on a channel.
- Garbage in bits 7:3: a design that echoes the written byte returns the wrong read data.
- A foreign address: a loose compare acknowledges it or changes the selection.
- The window between the last data ACK and STOP: a design that commits early shows the new enable before STOP, and the per-cycle model catches it.
- Simultaneous requests on channels 0 and 3 with channel 1 selected: a prioritising or selection-gated design drops a status bit or fails to assert the merged output.
- Requests that toggle during a two-byte read: a design that samples at the wrong moment returns the wrong status in one of the two bytes.

// File: rtl/i2c_chsel_pkg.sv
`timescale 1ns/1ps
package i2c_chsel_pkg;
  localparam int unsigned NUM_CH  = 4;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned IDX_W   = $clog2(NUM_CH);
  localparam int unsigned SEL_W   = IDX_W + 1;
  localparam int unsigned STRAP_W = 3;

  typedef enum logic [2:0] {
    SL_IDLE,
    SL_ADDR,
    SL_AACK,
    SL_WRX,
    SL_WACK,
    SL_RDX,
    SL_RACK
  } slv_state_e;
endpackage

// File: rtl/i2c_cs_sync.sv
`timescale 1ns/1ps
// Two-stage synchroniser with a parameterised reset level.
module i2c_cs_sync #(
  parameter int unsigned   W       = 1,
  parameter logic [W-1:0]  RST_VAL = {W{1'b1}}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/i2c_cs_slave.sv
`timescale 1ns/1ps
// Oversampling I2C slave front end: address match, ACK, byte write, byte read.
module i2c_cs_slave
  import i2c_chsel_pkg::*;
#(
  parameter int unsigned BYTE_W = DATA_W,
  parameter int unsigned WR_W   = SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [BYTE_W-2:0] dev_addr,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [WR_W-1:0]   wr_sel,
  output logic              stop_det,
  output logic              scl_seen
);
  localparam int unsigned CNT_W = $clog2(BYTE_W) + 1;

  logic [1:0]        line_s;
  logic              scl_s, sda_s, scl_p, sda_p;
  logic              scl_rise, scl_fall, start_det, byte_done;
  slv_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              oe_q, oe_d, rw_q, rw_d, nack_q, nack_d;

  i2c_cs_sync #(.W(2), .RST_VAL(2'b11)) u_line_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({scl_in, sda_in}),
    .q     (line_s)
  );

  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  assign byte_done = (cnt_q == CNT_W'(BYTE_W));

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    oe_d    = oe_q;
    rw_d    = rw_q;
    nack_d  = nack_q;
    if (stop_det) begin
      state_d = SL_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = SL_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        SL_ADDR, SL_WRX: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + CNT_W'(1);
          end else if (scl_fall && byte_done) begin
            if (state_q == SL_WRX) begin
              state_d = SL_WACK;
              oe_d    = 1'b1;
            end else if (sh_q[BYTE_W-1:1] == dev_addr) begin
              state_d = SL_AACK;
              oe_d    = 1'b1;
              rw_d    = sh_q[0];
            end else begin
              state_d = SL_IDLE;
            end
          end
        end
        SL_AACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              sh_d    = rd_byte;
              oe_d    = ~rd_byte[BYTE_W-1];
              state_d = SL_RDX;
            end else begin
              oe_d    = 1'b0;
              state_d = SL_WRX;
            end
          end
        end
        SL_WACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            cnt_d   = '0;
            state_d = SL_WRX;
          end
        end
        SL_RDX: begin
          if (scl_rise) begin
            cnt_d = cnt_q + CNT_W'(1);
          end else if (scl_fall) begin
            if (byte_done) begin
              oe_d    = 1'b0;
              state_d = SL_RACK;
            end else begin
              sh_d = {sh_q[BYTE_W-2:0], 1'b0};
              oe_d = ~sh_q[BYTE_W-2];
            end
          end
        end
        SL_RACK: begin
          if (scl_rise) begin
            nack_d = sda_s;
          end else if (scl_fall) begin
            if (!nack_q) begin
              sh_d    = rd_byte;
              oe_d    = ~rd_byte[BYTE_W-1];
              cnt_d   = '0;
              state_d = SL_RDX;
            end else begin
              state_d = SL_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SL_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      nack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      oe_q    <= oe_d;
      rw_q    <= rw_d;
      nack_q  <= nack_d;
    end
  end

  assign wr_stb   = (state_q == SL_WRX) && scl_fall && byte_done;
  assign wr_sel   = sh_q[WR_W-1:0];
  assign sda_oe   = oe_q;
  assign scl_seen = scl_s;
endmodule

// File: rtl/i2c_cs_regs.sv
`timescale 1ns/1ps
// Control register, channel enable decode and request aggregation.
module i2c_cs_regs
  import i2c_chsel_pkg::*;
#(
  parameter int unsigned NCH    = NUM_CH,
  parameter int unsigned BYTE_W = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic              stop_det,
  input  logic [NCH-1:0]    irq_n_in,
  output logic [NCH-1:0]    chan_en,
  output logic              irq_n_out,
  output logic [BYTE_W-1:0] rd_byte
);
  localparam int unsigned IW    = $clog2(NCH);
  localparam int unsigned PAD_W = BYTE_W - NCH - SEL_W;

  logic [NCH-1:0]   irq_s_n;
  logic [SEL_W-1:0] ctrl_q, pend_q;
  logic             pend_v_q, pend_v_d;
  logic             commit;

  i2c_cs_sync #(.W(NCH), .RST_VAL({NCH{1'b1}})) u_irq_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (irq_n_in),
    .q     (irq_s_n)
  );

  // A selection waits in pend_q until the STOP that closes its transfer
  assign commit = stop_det & pend_v_q;

  always_comb begin
    pend_v_d = pend_v_q;
    if (wr_stb)        pend_v_d = 1'b1;
    else if (stop_det) pend_v_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else begin
      pend_v_q <= pend_v_d;
      if (wr_stb) pend_q <= wr_sel;
      if (commit) ctrl_q <= pend_q;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    assign chan_en[c] = ctrl_q[IW] && (ctrl_q[IW-1:0] == IW'(c));
  end

  assign irq_n_out = &irq_s_n;
  assign rd_byte   = {~irq_s_n, {PAD_W{1'b0}}, ctrl_q};
endmodule

// File: rtl/i2c_chan_sel.sv
`timescale 1ns/1ps
// Top: I2C-controlled four-way channel selector with merged service request.
module i2c_chan_sel
  import i2c_chsel_pkg::*;
#(
  parameter logic [DATA_W-2-STRAP_W:0] ADDR_HI = 4'b1110
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] addr_strap,
  input  logic [NUM_CH-1:0]  irq_n_in,
  output logic [NUM_CH-1:0]  chan_en,
  output logic               irq_n_out
);
  logic              wr_stb;
  logic [SEL_W-1:0]  wr_sel;
  logic              stop_seen;
  logic              scl_seen;
  logic [DATA_W-1:0] rd_byte;

  i2c_cs_slave #(.BYTE_W(DATA_W), .WR_W(SEL_W)) u_slave (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .dev_addr ({ADDR_HI, addr_strap}),
    .rd_byte  (rd_byte),
    .sda_oe   (sda_oe),
    .wr_stb   (wr_stb),
    .wr_sel   (wr_sel),
    .stop_det (stop_seen),
    .scl_seen (scl_seen)
  );

  i2c_cs_regs #(.NCH(NUM_CH), .BYTE_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .wr_sel    (wr_sel),
    .stop_det  (stop_seen),
    .irq_n_in  (irq_n_in),
    .chan_en   (chan_en),
    .irq_n_out (irq_n_out),
    .rd_byte   (rd_byte)
  );
endmodule

// File: rtl/i2c_chan_sel_chk.sv
`timescale 1ns/1ps
module i2c_chan_sel_chk
  import i2c_chsel_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] chan_en,
  input logic [NUM_CH-1:0] irq_n_in,
  input logic              irq_n_out,
  input logic              sda_oe,
  input logic              stop_seen,
  input logic              scl_seen
);
  logic [1:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cyc_q <= 2'd0;
    else if (cyc_q != 2'd3)  cyc_q <= cyc_q + 2'd1;
  end

  AST_EN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_en)) else $error("more than one channel enabled"); // R4

  AST_EN_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en != $past(chan_en)) |-> $past(stop_seen)) else $error("enable changed without STOP"); // R5

  // merged request follows the inputs two edges later (also covers R7)
  AST_IRQ_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 2'd2) |-> (irq_n_out == &$past(irq_n_in, 2))) else $error("merged request mismatch"); // R10

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_seen) else $error("SDA drive changed while SCL high"); // R1
endmodule

bind i2c_chan_sel i2c_chan_sel_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chan_en   (chan_en),
  .irq_n_in  (irq_n_in),
  .irq_n_out (irq_n_out),
  .sda_oe    (sda_oe),
  .stop_seen (stop_seen),
  .scl_seen  (scl_seen)
);

// File: tb/i2c_chan_sel_tb.sv
`timescale 1ns/1ps
module i2c_chan_sel_tb;
  localparam int HALF = 10;           // 50 MHz
  localparam int QTR  = 8;            // clocks per quarter bus bit
  localparam logic [3:0] DEV_HI = 4'b1110;
  localparam logic [2:0] STRAP  = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #HALF clk = ~clk;

  logic       m_scl, m_sda_low;
  logic [3:0] irq_drv;
  logic       sda_oe, irq_n_out;
  logic [3:0] chan_en;
  wire        sda_line = ~(m_sda_low | sda_oe);

  i2c_chan_sel u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_in     (m_scl),
    .sda_in     (sda_line),
    .sda_oe     (sda_oe),
    .addr_strap (STRAP),
    .irq_n_in   (irq_drv),
    .chan_en    (chan_en),
    .irq_n_out  (irq_n_out)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // behavioural model state
  logic [2:0] m_ctrl = 3'b000;
  logic [2:0] m_pend = 3'b000;
  bit         m_pend_v = 1'b0;

  function automatic logic [3:0] en_of(input logic [2:0] c);
    return c[2] ? (4'b0001 << c[1:0]) : 4'b0000;
  endfunction

  function automatic logic [7:0] rd_of(input logic [3:0] irq, input logic [2:0] c);
    return {~irq, 1'b0, c};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against delayed model values
  logic [3:0] en_hist[$];
  logic       irq_hist[$];
  always begin
    @(posedge clk);
    #5;
    if (!rst_n) begin
      en_hist.delete();
      irq_hist.delete();
    end else begin
      en_hist.push_back(en_of(m_ctrl));
      irq_hist.push_back(&irq_drv);
      if (en_hist.size() > 3) void'(en_hist.pop_front());
      if (irq_hist.size() > 2) void'(irq_hist.pop_front());
      if (en_hist.size() == 3)
        chk("R5 per-cycle chan_en", {4'b0, chan_en}, {4'b0, en_hist[0]});
      if (irq_hist.size() == 2)
        chk("R10 per-cycle irq_n_out", {7'b0, irq_n_out}, {7'b0, irq_hist[0]});
    end
  end

  task automatic q();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    m_sda_low = ~b; q(); m_scl = 1'b1; q(); q(); m_scl = 1'b0; q();
  endtask

  task automatic recv_bit(output logic b);
    m_sda_low = 1'b0; q(); m_scl = 1'b1; q(); b = sda_line; q(); m_scl = 1'b0; q();
  endtask

  task automatic i2c_start();
    m_sda_low = 1'b0; q(); m_scl = 1'b1; q(); m_sda_low = 1'b1; q(); m_scl = 1'b0; q();
  endtask

  task automatic i2c_stop();
    m_sda_low = 1'b1; q(); m_scl = 1'b1; q();
    m_sda_low = 1'b0;
    if (m_pend_v) m_ctrl = m_pend;
    m_pend_v = 1'b0;
    q();
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(a);
    ack = ~a;
  endtask

  task automatic read_byte(input bit mack, input logic [3:0] irq_mid, output logic [7:0] b);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(x);
      b[i] = x;
      if (i == 4) irq_drv = irq_mid;
    end
    send_bit(~mack);
  endtask

  task automatic wr_txn(input logic [2:0] strap, input logic [7:0] data, input string tag,
                        input bit exp_ack);
    logic a;
    i2c_start();
    write_byte({DEV_HI, strap, 1'b0}, a);
    chk({tag, " address ack"}, {7'b0, a}, {7'b0, exp_ack});
    write_byte(data, a);
    chk({tag, " data ack"}, {7'b0, a}, {7'b0, exp_ack});
    if (exp_ack) begin m_pend = data[2:0]; m_pend_v = 1'b1; end
    i2c_stop();
  endtask

  task automatic rd_txn(input string tag, input bit two, input logic [3:0] irq_mid,
                        input logic [7:0] exp0, input logic [7:0] exp1);
    logic a;
    logic [7:0] b0, b1;
    i2c_start();
    write_byte({DEV_HI, STRAP, 1'b1}, a);
    chk("R1 read address ack", {7'b0, a}, 8'h01);
    read_byte(two, irq_mid, b0);
    chk({tag, " read byte 0"}, b0, exp0);
    if (two) begin
      read_byte(1'b0, irq_mid, b1);
      chk({tag, " read byte 1"}, b1, exp1);
    end
    i2c_stop();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    logic a;
    m_scl = 1'b1; m_sda_low = 1'b0; irq_drv = 4'hF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 chan_en after reset", {4'b0, chan_en}, 8'h00);
    chk("R6 irq_n_out after reset", {7'b0, irq_n_out}, 8'h01);
    chk("R6 sda_oe after reset", {7'b0, sda_oe}, 8'h00);
    rd_txn("R6 reset register", 1'b0, irq_drv, 8'h00, 8'h00);

    // R5: selection held back until STOP, then R4 applies it
    i2c_start();
    write_byte({DEV_HI, STRAP, 1'b0}, a);
    chk("R1 write address ack", {7'b0, a}, 8'h01);
    write_byte(8'h06, a);
    chk("R1 data ack", {7'b0, a}, 8'h01);
    m_pend = 3'b110; m_pend_v = 1'b1;
    q(); q();
    chk("R5 no change before STOP", {4'b0, chan_en}, 8'h00);
    i2c_stop();
    q();
    chk("R4 channel 2 enabled", {4'b0, chan_en}, 8'h04);
    rd_txn("R9 selection readback", 1'b0, irq_drv, rd_of(4'hF, 3'b110), 8'h00);

    wr_txn(STRAP, 8'h03, "R3", 1'b1);
    q();
    chk("R3 disable flag clear", {4'b0, chan_en}, 8'h00);
    rd_txn("R3 readback", 1'b0, irq_drv, rd_of(4'hF, 3'b011), 8'h00);

    wr_txn(STRAP, 8'hFD, "R9", 1'b1);
    q();
    chk("R9 upper write bits ignored", {4'b0, chan_en}, 8'h02);
    rd_txn("R9 bits 7:3 not echoed", 1'b0, irq_drv, rd_of(4'hF, 3'b101), 8'h00);

    wr_txn(3'b001, 8'h07, "R2 foreign", 1'b0);
    q();
    chk("R2 selection unchanged", {4'b0, chan_en}, 8'h02);

    irq_drv = 4'b1110;
    q();
    chk("R7 request on unselected channel", {7'b0, irq_n_out}, 8'h00);
    rd_txn("R8 channel 0 pending", 1'b0, irq_drv, 8'h15, 8'h00);

    irq_drv = 4'b0110;
    q();
    chk("R7 two requests", {7'b0, irq_n_out}, 8'h00);
    rd_txn("R8 channels 3 and 0 pending", 1'b0, irq_drv, 8'h95, 8'h00);

    irq_drv = 4'hF;
    q();
    chk("R7 released, not latched", {7'b0, irq_n_out}, 8'h01);
    rd_txn("R8 none pending", 1'b0, irq_drv, 8'h05, 8'h00);

    irq_drv = 4'b1011;
    q();
    rd_txn("R11 per-byte capture", 1'b1, 4'b0111, 8'h45, 8'h85);
    irq_drv = 4'hF;

    // R4: last of several bytes in one transfer wins
    i2c_start();
    write_byte({DEV_HI, STRAP, 1'b0}, a);
    write_byte(8'h04, a);
    m_pend = 3'b100; m_pend_v = 1'b1;
    write_byte(8'h07, a);
    chk("R1 second data ack", {7'b0, a}, 8'h01);
    m_pend = 3'b111;
    i2c_stop();
    q();
    chk("R4 last byte decides", {4'b0, chan_en}, 8'h08);

    q();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule